// File: doc/BRIEF.md
# Least-Recently-Served Matrix Arbiter

This block chooses one winner per cycle among `N_REQ` requesters that compete for a single shared resource. A typical resource is one crossbar output port or one output virtual channel. Fairness is strictly least-recently-served. The block keeps one precedence bit for every unordered pair of requesters, so the storage holds a complete ordering of all inputs rather than a single pointer.

The grant is combinational from the request vector and the stored precedence. The caller raises `advance_i` in a cycle where it actually uses the grant. Only then does the arbiter record the winner as most recently served, which makes it lose every pairwise contest on the next cycle. If the grant is not used, the precedence state holds, so a grant offered but not taken gives the winner no penalty.

Top module: `lrs_matrix_arbiter`

## Requirements
- R1: At most one bit of `grant_o` is high in any cycle.
- R2: A bit of `grant_o` is high only when the matching bit of `req_i` is high.
- R3: `grant_valid_o` is high exactly when any bit of `req_i` is high. When `req_i` is all zero, `grant_o` is all zero.
- R4: After reset the ranking is by index: a requester with a lower index beats every requester with a higher index.
- R5: When a grant is consumed (`advance_i` high while a grant is issued), the granted requester becomes lower in rank than every other requester from the next cycle on.
- R6: When `advance_i` is low, or no grant is issued, the ranking does not change. The same request vector then yields the same grant on the next cycle.
- R7: The grant goes to the requesting input that no other requesting input outranks. This is the requester served longest ago among those requesting.
- R8: An input that keeps requesting is granted before more than `N_REQ-1` consumed grants go to other inputs.
- R9: Suppose consumed grants went to requester 1 and then to requester 0, and then requesters 0, 1 and 2 request while each grant is consumed. The grants then go to 2, 1 and 0 in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Request vector, bit k for requester k |
| advance_i | input | 1 | High when the current grant is consumed, so the ranking is updated |
| grant_o | output | N_REQ | One-hot grant vector, or zero |
| grant_valid_o | output | 1 | High when a grant is issued |

## Verification
The arbiter is driven with several kinds of request pattern, and each separates different faults:
- A single active requester checks that the grant follows the request and that the ranking changes.
- All inputs requesting at once checks that the ranking rotates through every input, and catches a stuck or reversed precedence bit.
- The sequence of consumed grants to 1, then 0, then the group 0, 1, 2 checks the direction of the row and column update.
- Cycles with `advance_i` low between identical request vectors show whether the state moves without being consumed.
- Long runs of random requests with random advance are compared each cycle against a model that keeps an ordered list of requesters. These runs also measure how many grants each waiting input sees go to others.

// File: rtl/lrs_arb_pkg.sv
package lrs_arb_pkg;

   // Number of unordered pairs among n requesters.
   function automatic int unsigned pair_count(input int unsigned n);
      return (n * (n - 1)) / 2;
   endfunction

   // Flat position of the pair (lo, hi) with lo < hi in the triangular store.
   function automatic int unsigned pair_idx(input int unsigned lo,
                                            input int unsigned hi,
                                            input int unsigned n);
      return (lo * n) - ((lo * (lo + 1)) / 2) + (hi - lo - 1);
   endfunction

endpackage

// File: rtl/lrs_prec_store.sv
// Triangular precedence store. Bit for pair (lo,hi) high means lo outranks hi.
module lrs_prec_store #(
   parameter int unsigned N_REQ = 4,
   localparam int unsigned NPAIR = lrs_arb_pkg::pair_count(N_REQ)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             take_i,
   input  logic [N_REQ-1:0] winner_i,
   output logic [NPAIR-1:0] prec_o
);

   for (genvar lo = 0; lo < N_REQ; lo++) begin : g_lo
      for (genvar hi = lo + 1; hi < N_REQ; hi++) begin : g_hi
         localparam int unsigned P = lrs_arb_pkg::pair_idx(lo, hi, N_REQ);
         logic bit_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               bit_q <= 1'b1;                  // lower index ranks first
            end else if (take_i && winner_i[lo]) begin
               bit_q <= 1'b0;                  // served one drops below hi
            end else if (take_i && winner_i[hi]) begin
               bit_q <= 1'b1;                  // served one drops below lo
            end
         end
         assign prec_o[P] = bit_q;
      end
   end

endmodule

// File: rtl/lrs_grant_solve.sv
// Combinational grant: a requester wins when no active rival outranks it.
module lrs_grant_solve #(
   parameter int unsigned N_REQ = 4,
   localparam int unsigned NPAIR = lrs_arb_pkg::pair_count(N_REQ)
) (
   input  logic [N_REQ-1:0] req_i,
   input  logic [NPAIR-1:0] prec_i,
   output logic [N_REQ-1:0] grant_o,
   output logic             any_o
);

   for (genvar k = 0; k < N_REQ; k++) begin : g_cand
      logic [N_REQ-1:0] blocked_by;
      for (genvar j = 0; j < N_REQ; j++) begin : g_rival
         if (j == k) begin : g_self
            assign blocked_by[j] = 1'b0;
         end else if (j < k) begin : g_low
            assign blocked_by[j] = req_i[j] & prec_i[lrs_arb_pkg::pair_idx(j, k, N_REQ)];
         end else begin : g_high
            assign blocked_by[j] = req_i[j] & ~prec_i[lrs_arb_pkg::pair_idx(k, j, N_REQ)];
         end
      end
      assign grant_o[k] = req_i[k] & ~(|blocked_by);
   end

   assign any_o = |req_i;

endmodule

// File: rtl/lrs_matrix_arbiter.sv
module lrs_matrix_arbiter #(
   parameter int unsigned N_REQ = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_REQ-1:0] req_i,
   input  logic             advance_i,
   output logic [N_REQ-1:0] grant_o,
   output logic             grant_valid_o
);

   localparam int unsigned NPAIR = lrs_arb_pkg::pair_count(N_REQ);

   if (N_REQ < 2) begin : g_bad_n
      $error("lrs_matrix_arbiter: N_REQ must be at least 2");
   end
   if (N_REQ > 32) begin : g_big_n
      $error("lrs_matrix_arbiter: N_REQ above 32 is not supported");
   end

   logic [NPAIR-1:0] prec;
   logic [N_REQ-1:0] grant;
   logic             any_req;
   logic             take;

   lrs_grant_solve #(.N_REQ(N_REQ)) u_solve (
      .req_i   (req_i),
      .prec_i  (prec),
      .grant_o (grant),
      .any_o   (any_req)
   );

   assign take = advance_i & any_req;

   lrs_prec_store #(.N_REQ(N_REQ)) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .take_i   (take),
      .winner_i (grant),
      .prec_o   (prec)
   );

   assign grant_o       = grant;
   assign grant_valid_o = any_req;

endmodule

// File: rtl/lrs_arb_checker.sv
module lrs_arb_checker #(
   parameter int unsigned N_REQ = 4
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [N_REQ-1:0] req_i,
   input logic             advance_i,
   input logic [N_REQ-1:0] grant_o,
   input logic             grant_valid_o
);

   AST_GRANT_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o)); // R1

   AST_GRANT_REQUESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o & ~req_i) == '0); // R2

   AST_VALID_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_valid_o == (grant_o != '0)) && (grant_valid_o == (req_i != '0))); // R3

   AST_SERVED_LOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance_i && grant_valid_o) |=>
      (((grant_o & $past(grant_o)) == '0) || ($countones(req_i) < 2))); // R5

   AST_HOLD_UNUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(advance_i && grant_valid_o) |=> ($stable(req_i) -> $stable(grant_o))); // R6

   for (genvar k = 0; k < N_REQ; k++) begin : g_wait
      int unsigned others_cnt;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            others_cnt <= 0;
         end else if (!req_i[k] || (advance_i && grant_o[k])) begin
            others_cnt <= 0;
         end else if (advance_i && grant_valid_o) begin
            others_cnt <= others_cnt + 1;
         end
      end
      AST_WAIT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
         others_cnt <= N_REQ - 1); // R8
   end

endmodule

bind lrs_matrix_arbiter lrs_arb_checker #(.N_REQ(N_REQ)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .req_i         (req_i),
   .advance_i     (advance_i),
   .grant_o       (grant_o),
   .grant_valid_o (grant_valid_o)
);

// File: tb/sim_lrs_matrix_arbiter.sv
`timescale 1ns/1ps
module sim_lrs_matrix_arbiter;

   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] req = '0;
   logic         adv = 1'b0;
   logic [N-1:0] grant;
   logic         valid;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   int order[$];
   int wait_cnt[N];

   always #4 clk = ~clk;

   lrs_matrix_arbiter #(.N_REQ(N)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .advance_i(adv),
      .grant_o(grant), .grant_valid_o(valid)
   );

   task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      order.delete();
      for (int k = 0; k < N; k++) begin
         order.push_back(k);
         wait_cnt[k] = 0;
      end
   endtask

   // Drive one cycle, compare against the ordered-list model, then update it.
   task automatic step(input logic [N-1:0] r, input logic a, input string tag);
      logic [N-1:0] exp_g;
      int win;
      @(negedge clk);
      req = r;
      adv = a;
      #1;
      exp_g = '0;
      win = -1;
      for (int p = 0; p < order.size(); p++) begin
         if (r[order[p]]) begin
            win = order[p];
            exp_g[win] = 1'b1;
            break;
         end
      end
      check_vec({tag, " grant"}, grant, exp_g);
      check_vec({tag, " valid"}, {{(N-1){1'b0}}, valid}, {{(N-1){1'b0}}, (r != '0)});
      @(posedge clk);
      for (int k = 0; k < N; k++) if (!r[k]) wait_cnt[k] = 0;
      if (a && win >= 0) begin
         for (int p = 0; p < order.size(); p++) begin
            if (order[p] == win) begin
               order.delete(p);
               break;
            end
         end
         order.push_back(win);
         for (int k = 0; k < N; k++) begin
            if (k == win || !r[k]) wait_cnt[k] = 0;
            else begin
               wait_cnt[k]++;
               checks++;
               if (wait_cnt[k] > N - 1) begin
                  errors++;
                  $display("FAIL R8 requester %0d waited actual=%0d expected<=%0d", k, wait_cnt[k], N - 1);
               end
            end
         end
      end
   endtask

   initial begin
      model_reset();
      #20;
      // R3 / R4 checked while reset is still applied and just after
      #1;
      check_vec("R3 reset no grant", grant, '0);
      @(negedge clk);
      rst_n = 1'b1;
      step('0, 1'b1, "R3 idle");
      step('1, 1'b0, "R4 all request");
      step(4'b1110, 1'b0, "R4 upper three");
      step(4'b1100, 1'b0, "R4 pair 2,3");
      // R5 consumption with all requesting rotates through every input
      for (int i = 0; i < 2 * N; i++) step('1, 1'b1, "R5 R7 R8 rotate");
      // R6 no advance: repeated identical requests keep the winner
      step(4'b1011, 1'b0, "R6 hold");
      step(4'b1011, 1'b0, "R6 hold");
      step(4'b1011, 1'b0, "R6 hold");
      step(4'b1011, 1'b1, "R6 consume");
      step(4'b1011, 1'b0, "R5 after consume");
      // R9 worked sequence from a fresh reset
      @(negedge clk);
      rst_n = 1'b0;
      model_reset();
      @(negedge clk);
      rst_n = 1'b1;
      step(4'b0010, 1'b1, "R9 serve 1");
      step(4'b0001, 1'b1, "R9 serve 0");
      step(4'b0111, 1'b1, "R9 expect 2");
      step(4'b0111, 1'b1, "R9 expect 1");
      step(4'b0111, 1'b1, "R9 expect 0");
      // random traffic
      for (int i = 0; i < 3000; i++) begin
         step(N'($urandom), 1'($urandom_range(0, 3) != 0), "R1 R2 R3 R7 random");
      end
      for (int i = 0; i < 400; i++) begin
         step(N'($urandom) | 4'b0100, 1'b1, "R7 R8 sticky requester");
      end
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule